// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns a serial RX line into bytes. It is armed by a two-step enable: the power bit is set first, then the receive bit. Once armed, it waits for a falling edge on the line. It confirms the start bit at the middle of the bit, then samples eight data bits, least significant first, at a programmed bit period. An optional parity bit follows, then a single stop bit. The completed byte moves from the shift register into a receive buffer that software reads later.

Three sticky flags record errors: overrun, parity and framing. A parity or framing problem never ends a frame early. The frame still runs to its stop-bit position. At the end of each frame the block raises one of two one-cycle pulses: a completion pulse for a clean frame, or an error pulse for a frame that had any error.

The flags are cleared by a read of the status register followed by a read of the buffer. While any flag is still set, or while the buffer still holds an unread byte, the next frame counts as an overrun. An overrun frame leaves the buffer unchanged.

Top module: `uart_rx_status`

## Requirements
- R1: The receiver is armed only when `pwr_en_i` is already high in the cycle before `rx_en_i` goes high. Raising both in the same cycle, or raising `rx_en_i` before `pwr_en_i`, leaves the receiver unarmed, and frames are then ignored.
- R2: When armed and idle, a falling edge on the synchronised line loads a half-bit count (divisor/2 clocks). If the line is low when that count expires, a frame starts. If it is high, the receiver returns to idle without any pulse.
- R3: One bit period is `divisor` clocks, and a divisor below 4 is treated as 4. The eight data bits arrive least significant bit first.
- R4: `par_mode_i` selects the parity bit. 0 means no parity bit. 1 means even parity over the data bits plus the parity bit. 2 means odd parity. 3 means the parity bit must be 0. A mismatch sets `err_par_o`.
- R5: For a frame with no error, the byte appears on `buf_data_o` and `done_irq_o` pulses for exactly one cycle, once per frame.
- R6: A frame with any error (overrun, parity or framing) pulses `err_irq_o` instead of `done_irq_o`. A parity error does not end the frame early: the stop bit is still checked and the pulse comes at the frame's end.
- R7: A low stop bit sets `err_frm_o`.
- R8: If the buffer holds an unread byte, or any error flag is set, when a frame completes, `err_ovr_o` is set and `buf_data_o` keeps its old value.
- R9: The flags stay set until a `stat_rd_i` pulse is followed later by a `buf_rd_i` pulse. A `buf_rd_i` pulse alone only frees the buffer and leaves the flags set.
- R10: Only one stop bit is checked. A second stop bit is treated as idle line, and a frame that starts right after it is received.
- R11: Dropping either enable returns the receiver to idle at once, so a frame in progress produces no pulse and leaves the buffer unchanged.
- R12: After reset the buffer, all flags and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| pwr_en_i | input | 1 | Power enable, must be set before the receive enable |
| rx_en_i | input | 1 | Receive enable |
| baud_div_i | input | DIV_W | Clocks per bit; values below 4 are treated as 4 |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 zero |
| stat_rd_i | input | 1 | Status register read strobe |
| buf_rd_i | input | 1 | Receive buffer read strobe |
| buf_data_o | output | DATA_W | Receive buffer contents |
| err_ovr_o | output | 1 | Sticky overrun flag |
| err_par_o | output | 1 | Sticky parity error flag |
| err_frm_o | output | 1 | Sticky framing error flag |
| done_irq_o | output | 1 | One-cycle pulse for a clean frame |
| err_irq_o | output | 1 | One-cycle pulse for a frame with an error |

## Verification
The assertions check several things on every cycle:
- the arming order
- the disarm-to-idle path
- the return to idle after a rejected start
- that the buffer keeps its value on overrun and takes the shift register on a clean completion
- that the two pulses never coincide and follow only a completed frame
- that no flag falls except through the status-then-buffer read sequence

Other behaviours can only be shown by the bench's frame scenarios:
- data bit order
- the parity rules of each mode
- divisor clamping
- a second stop bit acting as idle
- a parity error that does not shorten the frame
- a buffer-only read that leaves the flags set

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
  localparam logic [1:0] PAR_ZERO = 2'd3;

  // ones_odd: XOR reduction of the data bits; pbit: received parity bit
  function automatic logic parity_bad(input logic ones_odd, input logic pbit,
                                      input logic [1:0] mode);
    case (mode)
      PAR_EVEN: return (ones_odd ^ pbit) != 1'b0;
      PAR_ODD:  return (ones_odd ^ pbit) == 1'b0;
      PAR_ZERO: return pbit != 1'b0;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rx_arm_sync.sv
module rx_arm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic pwr_en_i,
  input  logic rx_en_i,
  output logic rx_s_o,
  output logic fall_o,
  output logic armed_o
);
  logic rx_meta, rx_s, rx_prev;
  logic pwr_q, rxen_q, armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_meta <= rx_i;
      rx_s    <= rx_meta;
      rx_prev <= rx_s;
    end
  end

  // Arming needs power already on when receive enable rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      rxen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      pwr_q   <= pwr_en_i;
      rxen_q  <= rx_en_i;
      armed_q <= pwr_en_i & rx_en_i & (armed_q | (pwr_q & ~rxen_q));
    end
  end

  assign rx_s_o  = rx_s;
  assign fall_o  = rx_prev & ~rx_s;
  assign armed_o = armed_q;
endmodule

// File: rtl/rx_baud_timer.sv
module rx_baud_timer #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_half_i,
  input  logic             load_full_i,
  input  logic             stop_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d < MIN_V) ? MIN_V : d;
  endfunction

  logic [DIV_W-1:0] cnt_q, eff, half_ld, full_ld;
  logic             run_q;

  assign eff     = eff_div(div_i);
  assign half_ld = (eff >> 1) - DIV_W'(1);
  assign full_ld = eff - DIV_W'(1);
  assign tick_o  = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (load_half_i) begin
      cnt_q <= half_ld;
      run_q <= 1'b1;
    end else if (load_full_i) begin
      cnt_q <= full_ld;
      run_q <= 1'b1;
    end else if (run_q && cnt_q != '0) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end else if (tick_o) begin
      run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed_i,
  input  logic              fall_i,
  input  logic              rx_s_i,
  input  logic              tick_i,
  input  logic [1:0]        par_mode_i,
  output logic              load_half_o,
  output logic              load_full_o,
  output logic              stop_timer_o,
  output logic              start_ok_o,
  output logic              false_start_o,
  output logic              frame_done_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] shift_o,
  output logic              par_bit_o,
  output logic              stop_bit_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;
  logic              par_en;

  assign par_en        = (par_mode_i != PAR_NONE);
  assign load_half_o   = armed_i && state_q == ST_IDLE && fall_i;
  assign start_ok_o    = armed_i && state_q == ST_START && tick_i && !rx_s_i;
  assign false_start_o = armed_i && state_q == ST_START && tick_i && rx_s_i;
  assign frame_done_o  = armed_i && state_q == ST_STOP && tick_i;
  assign load_full_o   = start_ok_o ||
                         (armed_i && tick_i && (state_q == ST_DATA || state_q == ST_PAR));
  assign stop_timer_o  = !armed_i || false_start_o || frame_done_o;
  assign busy_o        = state_q != ST_IDLE;
  assign shift_o       = shift_q;
  assign par_bit_o     = par_q;
  assign stop_bit_o    = rx_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
    end else if (!armed_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE:  if (load_half_o) state_q <= ST_START;
        ST_START: if (tick_i) begin
          state_q <= rx_s_i ? ST_IDLE : ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: if (tick_i) begin
          shift_q <= {rx_s_i, shift_q[DATA_W-1:1]};
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= par_en ? ST_PAR : ST_STOP;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_PAR: if (tick_i) begin
          par_q   <= rx_s_i;
          state_q <= ST_STOP;
        end
        ST_STOP: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] shift_i,
  input  logic              par_bit_i,
  input  logic              stop_bit_i,
  input  logic [1:0]        par_mode_i,
  input  logic              stat_rd_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              ovr_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              done_irq_o,
  output logic              err_irq_o,
  output logic              ovr_cond_o,
  output logic              stat_seen_o
);
  logic [DATA_W-1:0] buf_q;
  logic buf_full_q, seen_q, ovr_q, par_q, frm_q;
  logic par_err, frm_err, new_err, clr;
  logic ovr_n, par_n, frm_n;

  assign ovr_cond_o = buf_full_q | ovr_q | par_q | frm_q;
  assign par_err    = parity_bad(^shift_i, par_bit_i, par_mode_i);
  assign frm_err    = ~stop_bit_i;
  assign new_err    = ovr_cond_o | par_err | frm_err;
  assign clr        = buf_rd_i & seen_q;

  always_comb begin
    ovr_n = clr ? 1'b0 : ovr_q;
    par_n = clr ? 1'b0 : par_q;
    frm_n = clr ? 1'b0 : frm_q;
    if (frame_done_i) begin
      ovr_n = ovr_n | ovr_cond_o;
      par_n = par_n | par_err;
      frm_n = frm_n | frm_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      seen_q     <= 1'b0;
      ovr_q      <= 1'b0;
      par_q      <= 1'b0;
      frm_q      <= 1'b0;
      done_irq_o <= 1'b0;
      err_irq_o  <= 1'b0;
    end else begin
      ovr_q      <= ovr_n;
      par_q      <= par_n;
      frm_q      <= frm_n;
      done_irq_o <= frame_done_i & ~new_err;
      err_irq_o  <= frame_done_i & new_err;
      if (buf_rd_i) begin
        buf_full_q <= 1'b0;
        seen_q     <= 1'b0;
      end
      if (stat_rd_i) seen_q <= 1'b1;
      if (frame_done_i && !ovr_cond_o) begin
        buf_q      <= shift_i;
        buf_full_q <= 1'b1;
      end
    end
  end

  assign buf_o       = buf_q;
  assign ovr_o       = ovr_q;
  assign par_o       = par_q;
  assign frm_o       = frm_q;
  assign stat_seen_o = seen_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              pwr_en_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [1:0]        par_mode_i,
  input  logic              stat_rd_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              err_ovr_o,
  output logic              err_par_o,
  output logic              err_frm_o,
  output logic              done_irq_o,
  output logic              err_irq_o
);
  // Named internal events, also observed by the bound checker.
  logic              rx_s_w, fall_w, armed_w, tick_w;
  logic              load_half_w, load_full_w, stop_timer_w;
  logic              ev_start_ok, ev_false_start, ev_frame_done, busy_w;
  logic [DATA_W-1:0] shift_w;
  logic              par_bit_w, stop_bit_w, ovr_cond_w, stat_seen_w;

  rx_arm_sync u_arm (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .pwr_en_i(pwr_en_i),
    .rx_en_i(rx_en_i), .rx_s_o(rx_s_w), .fall_o(fall_w), .armed_o(armed_w)
  );

  rx_baud_timer #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .load_half_i(load_half_w),
    .load_full_i(load_full_w), .stop_i(stop_timer_w), .tick_o(tick_w)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .armed_i(armed_w), .fall_i(fall_w),
    .rx_s_i(rx_s_w), .tick_i(tick_w), .par_mode_i(par_mode_i),
    .load_half_o(load_half_w), .load_full_o(load_full_w),
    .stop_timer_o(stop_timer_w), .start_ok_o(ev_start_ok),
    .false_start_o(ev_false_start), .frame_done_o(ev_frame_done),
    .busy_o(busy_w), .shift_o(shift_w), .par_bit_o(par_bit_w),
    .stop_bit_o(stop_bit_w)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .frame_done_i(ev_frame_done), .shift_i(shift_w),
    .par_bit_i(par_bit_w), .stop_bit_i(stop_bit_w), .par_mode_i(par_mode_i),
    .stat_rd_i(stat_rd_i), .buf_rd_i(buf_rd_i), .buf_o(buf_data_o),
    .ovr_o(err_ovr_o), .par_o(err_par_o), .frm_o(err_frm_o),
    .done_irq_o(done_irq_o), .err_irq_o(err_irq_o),
    .ovr_cond_o(ovr_cond_w), .stat_seen_o(stat_seen_w)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en_i,
  input logic              rx_en_i,
  input logic              buf_rd_i,
  input logic              armed_w,
  input logic              busy_w,
  input logic              ev_false_start,
  input logic              ev_frame_done,
  input logic              ovr_cond_w,
  input logic              stat_seen_w,
  input logic [DATA_W-1:0] shift_w,
  input logic [DATA_W-1:0] buf_data_o,
  input logic              err_ovr_o,
  input logic              err_par_o,
  input logic              err_frm_o,
  input logic              done_irq_o,
  input logic              err_irq_o
);
  assert_arm_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_w) |-> ($past(pwr_en_i) && $past(rx_en_i)));

  assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en_i || !rx_en_i) |=> !armed_w);

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_w |=> !busy_w);

  assert_false_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_false_start |=> !busy_w);

  assert_buffer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_done && !ovr_cond_w) |=> (buf_data_o == $past(shift_w)));

  assert_overrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_done && ovr_cond_w) |=> ($stable(buf_data_o) && err_ovr_o));

  assert_irq_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_irq_o && err_irq_o));

  assert_irq_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq_o || err_irq_o) |-> $past(ev_frame_done));

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_ovr_o) |-> ($past(buf_rd_i) && $past(stat_seen_w)));

  assert_par_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_par_o) |-> ($past(buf_rd_i) && $past(stat_seen_w)));

  assert_frm_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_frm_o) |-> ($past(buf_rd_i) && $past(stat_seen_w)));
endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en_i), .rx_en_i(rx_en_i),
  .buf_rd_i(buf_rd_i), .armed_w(armed_w), .busy_w(busy_w),
  .ev_false_start(ev_false_start), .ev_frame_done(ev_frame_done),
  .ovr_cond_w(ovr_cond_w), .stat_seen_w(stat_seen_w), .shift_w(shift_w),
  .buf_data_o(buf_data_o), .err_ovr_o(err_ovr_o), .err_par_o(err_par_o),
  .err_frm_o(err_frm_o), .done_irq_o(done_irq_o), .err_irq_o(err_irq_o)
);

// File: tb/test_uart_rx_status.sv
`timescale 1ns/1ps
module test_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1, pwr_en = 1'b0, rx_en = 1'b0;
  logic [7:0] div = 8'd16;
  logic [1:0] pmode = 2'd0;
  logic       stat_rd = 1'b0, buf_rd = 1'b0;
  logic [7:0] buf_data;
  logic       e_ovr, e_par, e_frm, done_irq, err_irq;

  always #4 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .pwr_en_i(pwr_en), .rx_en_i(rx_en),
    .baud_div_i(div), .par_mode_i(pmode), .stat_rd_i(stat_rd), .buf_rd_i(buf_rd),
    .buf_data_o(buf_data), .err_ovr_o(e_ovr), .err_par_o(e_par),
    .err_frm_o(e_frm), .done_irq_o(done_irq), .err_irq_o(err_irq)
  );

  typedef struct {
    bit         err;
    logic [7:0] data;
    bit         ovr, par, frm;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0, irq_cnt = 0;
  bit   finished = 0;

  // behavioural model state
  logic [7:0] m_buf = 8'h00;
  bit m_full = 0, m_seen = 0, m_ovr = 0, m_par = 0, m_frm = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit good_par(input logic [7:0] d, input logic [1:0] m);
    case (m)
      2'd1: return ^d;
      2'd2: return ~(^d);
      default: return 1'b0;
    endcase
  endfunction

  // per-clock comparison of pulses against the expected event queue
  always @(negedge clk) begin
    if (rst_n && (done_irq || err_irq)) begin
      irq_cnt++;
      if (q.size() == 0) begin
        chk(0, "R6", "unexpected pulse", {done_irq, err_irq}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(err_irq == e.err && done_irq == !e.err, e.req, "pulse kind",
            {done_irq, err_irq}, {!e.err, e.err});
        chk(buf_data == e.data, e.req, "buffer", buf_data, e.data);
        chk({e_ovr, e_par, e_frm} == {e.ovr, e.par, e.frm}, e.req, "flags",
            {e_ovr, e_par, e_frm}, {e.ovr, e.par, e.frm});
      end
    end
  end

  task automatic drive_bit(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // flip_par: invert the correct parity bit; expect: frame should be seen
  task automatic send_frame(input logic [7:0] d, input bit flip_par,
                            input logic stop_v, input bit two_stop,
                            input bit expect_rx, input string req, input int gap);
    int  nd;
    bit  pbit, perr, ferr, ovr;
    exp_t e;
    nd   = (div < 8'd4) ? 4 : int'(div);
    pbit = good_par(d, pmode) ^ flip_par;
    if (expect_rx) begin
      perr = (pmode != 2'd0) && flip_par;
      ferr = !stop_v;
      ovr  = m_full | m_ovr | m_par | m_frm;
      m_ovr |= ovr; m_par |= perr; m_frm |= ferr;
      if (!ovr) begin m_buf = d; m_full = 1; end
      e.err = ovr | perr | ferr; e.data = m_buf;
      e.ovr = m_ovr; e.par = m_par; e.frm = m_frm; e.req = req;
      q.push_back(e);
    end
    drive_bit(1'b0, nd);
    for (int i = 0; i < 8; i++) drive_bit(d[i], nd);
    if (pmode != 2'd0) drive_bit(pbit, nd);
    drive_bit(stop_v, nd);
    if (two_stop) drive_bit(1'b1, nd);
    rx = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    m_seen = 1;
  endtask

  task automatic rd_buf();
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
    m_full = 0;
    if (m_seen) begin m_ovr = 0; m_par = 0; m_frm = 0; end
    m_seen = 0;
  endtask

  task automatic check_regs(input string req);
    chk(buf_data == m_buf, req, "buffer", buf_data, m_buf);
    chk({e_ovr, e_par, e_frm} == {m_ovr, m_par, m_frm}, req, "flags",
        {e_ovr, e_par, e_frm}, {m_ovr, m_par, m_frm});
  endtask

  task automatic check_drained(input string req, input int cnt_before, input int n);
    chk(q.size() == 0, req, "pending pulses", q.size(), 0);
    chk(irq_cnt == cnt_before + n, req, "pulse count", irq_cnt, cnt_before + n);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(buf_data == 8'h00, "R12", "reset buffer", buf_data, 0);
    chk({e_ovr, e_par, e_frm, done_irq, err_irq} == 5'b0, "R12", "reset flags",
        {e_ovr, e_par, e_frm, done_irq, err_irq}, 0);

    // R1 wrong order: receive enable first, then power
    rx_en = 1'b1; repeat (3) @(negedge clk);
    pwr_en = 1'b1; repeat (3) @(negedge clk);
    c0 = irq_cnt;
    send_frame(8'h5C, 0, 1'b1, 0, 0, "R1", 48);
    check_drained("R1", c0, 0);
    check_regs("R1");
    // R1 correct order: power already on, receive enable rises
    rx_en = 1'b0; repeat (3) @(negedge clk);
    rx_en = 1'b1; repeat (3) @(negedge clk);

    // R3 R5 clean frame, LSB first
    c0 = irq_cnt;
    send_frame(8'hA5, 0, 1'b1, 0, 1, "R5", 48);
    check_drained("R5", c0, 1);
    rd_stat(); rd_buf(); check_regs("R3");
    send_frame(8'h01, 0, 1'b1, 0, 1, "R3", 48);
    rd_stat(); rd_buf();

    // R2 glitch shorter than half a bit is rejected
    c0 = irq_cnt;
    drive_bit(1'b0, 3); drive_bit(1'b1, 64);
    check_drained("R2", c0, 0);
    send_frame(8'h3C, 0, 1'b1, 0, 1, "R2", 48);
    check_drained("R2", c0, 1);
    rd_stat(); rd_buf();

    // R4 parity modes
    pmode = 2'd1;
    send_frame(8'h0F, 0, 1'b1, 0, 1, "R4", 48); rd_stat(); rd_buf();
    send_frame(8'h07, 1, 1'b1, 0, 1, "R4", 48); check_regs("R4"); rd_stat(); rd_buf();
    pmode = 2'd2;
    send_frame(8'h07, 0, 1'b1, 0, 1, "R4", 48); rd_stat(); rd_buf();
    send_frame(8'hF0, 1, 1'b1, 0, 1, "R4", 48); rd_stat(); rd_buf();
    pmode = 2'd3;
    send_frame(8'hFF, 0, 1'b1, 0, 1, "R4", 48); rd_stat(); rd_buf();
    send_frame(8'h12, 1, 1'b1, 0, 1, "R4", 48); check_regs("R4"); rd_stat(); rd_buf();
    // R6 parity error with a low stop bit: frame still runs to the stop bit
    pmode = 2'd1;
    send_frame(8'h81, 1, 1'b0, 0, 1, "R6", 48); check_regs("R6"); rd_stat(); rd_buf();
    pmode = 2'd0;

    // R7 framing error
    send_frame(8'h66, 0, 1'b0, 0, 1, "R7", 48); check_regs("R7");
    rd_stat(); rd_buf(); check_regs("R7");

    // R8 overrun keeps old byte
    send_frame(8'h11, 0, 1'b1, 0, 1, "R8", 48);
    send_frame(8'h22, 0, 1'b1, 0, 1, "R8", 48);
    check_regs("R8");
    // R9 buffer read alone leaves flags; next frame is overrun again
    rd_buf(); check_regs("R9");
    send_frame(8'h33, 0, 1'b1, 0, 1, "R9", 48);
    rd_stat(); check_regs("R9");
    rd_buf(); check_regs("R9");
    send_frame(8'h44, 0, 1'b1, 0, 1, "R9", 48);
    rd_stat(); rd_buf();

    // R10 two stop bits, next frame right after
    c0 = irq_cnt;
    send_frame(8'hC3, 0, 1'b1, 1, 1, "R10", 0);
    send_frame(8'h3A, 0, 1'b1, 1, 1, "R10", 48);
    check_drained("R10", c0, 2);
    rd_stat(); rd_buf(); check_regs("R10");

    // R3 divisor below minimum is treated as 4
    div = 8'd2;
    send_frame(8'h5A, 0, 1'b1, 0, 1, "R3", 16);
    rd_stat(); rd_buf(); check_regs("R3");
    div = 8'd16;

    // R11 disarm in the middle of a frame
    c0 = irq_cnt;
    drive_bit(1'b0, 16); drive_bit(1'b1, 16); drive_bit(1'b0, 16);
    rx_en = 1'b0;
    for (int i = 0; i < 7; i++) drive_bit(i[0], 16);
    drive_bit(1'b1, 64);
    check_drained("R11", c0, 0);
    check_regs("R11");
    rx_en = 1'b1; repeat (3) @(negedge clk);
    send_frame(8'h9E, 0, 1'b1, 0, 1, "R11", 48);
    check_drained("R11", c0, 1);
    check_regs("R11");

    finished = 1;
    summary();
    $finish;
  end
endmodule